// File: doc/BRIEF.md
# USB OUT Endpoint Event Monitor

This block watches the traffic of a single full-speed USB OUT endpoint and records what happens to it as sticky flags in a 32-bit status word. It takes already-decoded token strobes (SETUP, OUT, IN), a strobe marking the end of a data packet, the free word count of the receive FIFO, a software request to disable the endpoint, and a completion pulse from the transfer counter. It tracks protocol sequences rather than plain levels. It counts SETUP packets that arrive back to back. It marks the end of a setup stage when the next token is not a SETUP. On every OUT token it decides whether the following data packet fits in the FIFO.

For each data packet it gives an accept-or-drop verdict with a handshake choice, ACK or NAK. A packet that would overflow the FIFO is dropped, answered with NAK, and recorded as an overrun. Software clears flags by writing ones through a word-wide register write port. A second register, the enable mask, selects which flags drive the interrupt line.

Top module: `usb_out_ep_monitor`

## Requirements
- R1: One cycle after `xfer_done` is high at a clock edge, status bit 0 reads 1.
- R2: One cycle after `dis_req` is high at a clock edge, status bit 1 reads 1.
- R3: Status bit 3 is set one cycle after an IN or OUT token that follows a SETUP token with no other IN or OUT token in between. This happens only while `is_ctrl` is 1. Any IN or OUT token ends the setup stage whether or not the flag is set.
- R4: On an OUT token with `fifo_free` below `MPS_WORDS`, status bit 4 is set one cycle later.
- R5: When `pkt_done` follows an OUT or SETUP token, `hs_valid` is 1 in the next cycle. `hs_nak` is 1 in that cycle only when the last such token was an OUT token that saw too little FIFO space. A SETUP token is always answered with ACK. A `pkt_done` with no pending token gives no handshake.
- R6: Status bit 6 is set on the fourth and every later SETUP token in a row while `is_ctrl` is 1. The run count is cleared by any IN or OUT token.
- R7: A write with `wr_sel`=0 and `wr_be`=4'hF clears each status bit whose `wr_data` bit is 1. Bits written as 0 keep their value.
- R8: A write whose `wr_be` is not 4'hF changes neither the status word nor the enable mask.
- R9: If a flag's set event and a write-1 clear of that flag occur in the same cycle, the flag ends up 1.
- R10: Status bits 31:7, 5 and 2 always read 0, and so do the same bits of the mask.
- R11: `irq` is 1 exactly when some status bit and the same bit of the enable mask are both 1. A full-word write with `wr_sel`=1 loads the mask, and the mask resets to 0.
- R12: After reset the status word, `hs_valid`, `hs_nak` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tok_setup | input | 1 | SETUP token strobe |
| tok_out | input | 1 | OUT token strobe |
| tok_in | input | 1 | IN token strobe |
| is_ctrl | input | 1 | Endpoint is configured as a control endpoint |
| fifo_free | input | FREE_W | Free words in the receive FIFO |
| pkt_done | input | 1 | Data packet finished strobe |
| xfer_done | input | 1 | All assigned transactions finished |
| dis_req | input | 1 | Software disable request honoured |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects status (write 1 to clear), 1 selects enable mask |
| wr_be | input | 4 | Byte enables; only 4'hF takes effect |
| wr_data | input | 32 | Write data |
| status | output | 32 | Sticky status word |
| hs_valid | output | 1 | Handshake verdict valid |
| hs_nak | output | 1 | 1 = drop and NAK, 0 = accept and ACK |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a run of four SETUP tokens with no IN or OUT token in between while the endpoint is a control endpoint. Random token streams break such runs almost every time. A close second is a flag being set by hardware in the very cycle software clears it. The stimulus therefore starts with directed sequences: a run of five SETUPs, a SETUP followed by an OUT, an OUT against a nearly full FIFO followed by its data packet, and a completion pulse that lands on a clear of the same bit. A long random phase then follows, with SETUP weighted heavily and the FIFO free count spread around the packet-size threshold. A behavioural model follows every cycle.

// File: rtl/usb_out_ep_monitor.sv
module usb_out_ep_monitor #(
  parameter int MPS_WORDS = 16,
  parameter int FREE_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_setup,
  input  logic              tok_out,
  input  logic              tok_in,
  input  logic              is_ctrl,
  input  logic [FREE_W-1:0] fifo_free,
  input  logic              pkt_done,
  input  logic              xfer_done,
  input  logic              dis_req,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [3:0]        wr_be,
  input  logic [31:0]       wr_data,
  output logic [31:0]       status,
  output logic              hs_valid,
  output logic              hs_nak,
  output logic              irq
);
  localparam logic [31:0] VALID = 32'h0000_005B;
  localparam logic [FREE_W:0] NEED = (FREE_W+1)'(MPS_WORDS);

  logic [31:0] flags, mask, set_v, clr_v;
  logic [1:0]  run_cnt;
  logic        in_setup, pend, drop;
  logic        data_tok, short_room, full_wr;

  assign data_tok   = tok_in | tok_out;
  assign short_room = {1'b0, fifo_free} < NEED;
  assign full_wr    = wr_en & (wr_be == 4'hF);
  assign clr_v      = (full_wr & ~wr_sel) ? wr_data : 32'h0;

  always_comb begin
    set_v    = 32'h0;
    set_v[0] = xfer_done;
    set_v[1] = dis_req;
    set_v[3] = data_tok & in_setup & is_ctrl;
    set_v[4] = tok_out & short_room;
    set_v[6] = tok_setup & is_ctrl & (run_cnt == 2'd3);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      mask  <= '0;
    end else begin
      flags <= ((flags & ~clr_v) | set_v) & VALID;
      if (full_wr && wr_sel) mask <= wr_data & VALID;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt  <= '0;
      in_setup <= 1'b0;
    end else if (data_tok) begin
      run_cnt  <= '0;
      in_setup <= 1'b0;
    end else if (tok_setup) begin
      in_setup <= 1'b1;
      if (run_cnt != 2'd3) run_cnt <= run_cnt + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      drop     <= 1'b0;
      hs_valid <= 1'b0;
      hs_nak   <= 1'b0;
    end else begin
      hs_valid <= pkt_done & pend;
      hs_nak   <= pkt_done & pend & drop;
      if (tok_out) begin
        pend <= 1'b1;
        drop <= short_room;
      end else if (tok_setup) begin
        pend <= 1'b1;
        drop <= 1'b0;
      end else if (pkt_done) begin
        pend <= 1'b0;
      end
    end
  end

  assign status = flags;
  assign irq    = |(flags & mask);
endmodule

// File: rtl/usb_out_ep_monitor_chk.sv
module usb_out_ep_monitor_chk #(
  parameter int MPS_WORDS = 16,
  parameter int FREE_W    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tok_setup,
  input logic              tok_out,
  input logic              is_ctrl,
  input logic [FREE_W-1:0] fifo_free,
  input logic              xfer_done,
  input logic              dis_req,
  input logic              wr_en,
  input logic [3:0]        wr_be,
  input logic [31:0]       status,
  input logic              hs_valid,
  input logic              hs_nak,
  input logic              irq
);
  AST_XFER_SET: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> status[0]); // R1
  AST_DIS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    dis_req |=> status[1]); // R2
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_out && (int'(fifo_free) < MPS_WORDS)) |=> status[4]); // R4
  AST_NAK_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    hs_nak |-> hs_valid); // R5
  AST_B2B_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[6]) |-> $past(tok_setup && is_ctrl)); // R6
  AST_PART_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be != 4'hF) |=> ((status & $past(status)) == $past(status))); // R8
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (status & 32'hFFFF_FFA4) == 32'h0); // R10
  AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status != 32'h0)); // R11
endmodule

bind usb_out_ep_monitor usb_out_ep_monitor_chk #(.MPS_WORDS(MPS_WORDS), .FREE_W(FREE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tok_setup(tok_setup), .tok_out(tok_out),
  .is_ctrl(is_ctrl), .fifo_free(fifo_free), .xfer_done(xfer_done),
  .dis_req(dis_req), .wr_en(wr_en), .wr_be(wr_be), .status(status),
  .hs_valid(hs_valid), .hs_nak(hs_nak), .irq(irq)
);

// File: tb/usb_out_ep_monitor_tb.sv
`timescale 1ns/1ps
module usb_out_ep_monitor_tb;
  localparam int MPS = 16;
  localparam int FW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tok_setup = 0, tok_out = 0, tok_in = 0, is_ctrl = 1, pkt_done = 0;
  logic xfer_done = 0, dis_req = 0, wr_en = 0, wr_sel = 0;
  logic [FW-1:0] fifo_free = 8'd40;
  logic [3:0]  wr_be = 4'h0;
  logic [31:0] wr_data = 32'h0;
  logic [31:0] status;
  logic hs_valid, hs_nak, irq;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  usb_out_ep_monitor #(.MPS_WORDS(MPS), .FREE_W(FW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tok_setup(tok_setup), .tok_out(tok_out),
    .tok_in(tok_in), .is_ctrl(is_ctrl), .fifo_free(fifo_free),
    .pkt_done(pkt_done), .xfer_done(xfer_done), .dis_req(dis_req),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_be(wr_be), .wr_data(wr_data),
    .status(status), .hs_valid(hs_valid), .hs_nak(hs_nak), .irq(irq)
  );

  // behavioural reference
  int unsigned m_stat, m_mask, m_run;
  bit m_stage, m_pend, m_drop, m_hsv, m_hsn;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = 0; m_mask = 0; m_run = 0;
      m_stage = 0; m_pend = 0; m_drop = 0; m_hsv = 0; m_hsn = 0;
    end else begin
      int unsigned s, c;
      s = 0; c = 0;
      m_hsv = pkt_done && m_pend;
      m_hsn = m_hsv && m_drop;
      if (xfer_done) s |= 1;
      if (dis_req) s |= 2;
      if (tok_in || tok_out) begin
        if (m_stage && is_ctrl) s |= 8;
        m_stage = 0; m_run = 0;
      end
      if (tok_out) begin
        m_pend = 1; m_drop = (fifo_free < MPS);
        if (m_drop) s |= 16;
      end else if (tok_setup) begin
        m_stage = 1;
        m_run++;
        if (is_ctrl && m_run >= 4) s |= 64;
        m_pend = 1; m_drop = 0;
      end else if (pkt_done) m_pend = 0;
      if (wr_en && wr_be == 4'hF) begin
        if (wr_sel) m_mask = wr_data & 32'h5B;
        else c = wr_data;
      end
      m_stat = ((m_stat & ~c) | s) & 32'h5B;
    end
  end

  function automatic string tag_of(input logic [31:0] d);
    if (d[0]) return "R1";
    if (d[1]) return "R2";
    if (d[3]) return "R3";
    if (d[4]) return "R4";
    if (d[6]) return "R6";
    return "R10";
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      total++;
      if (status !== m_stat) begin
        bad++;
        $display("FAIL %s/R7/R9 status actual=%h expected=%h", tag_of(status ^ m_stat), status, m_stat);
      end
      total++;
      if (hs_valid !== m_hsv || hs_nak !== m_hsn) begin
        bad++;
        $display("FAIL R5 handshake actual=%b%b expected=%b%b", hs_valid, hs_nak, m_hsv, m_hsn);
      end
      total++;
      if (irq !== |(m_stat & m_mask)) begin
        bad++;
        $display("FAIL R11 irq actual=%b expected=%b", irq, |(m_stat & m_mask));
      end
    end
  end

  task automatic clr_in();
    tok_setup = 0; tok_out = 0; tok_in = 0; pkt_done = 0;
    xfer_done = 0; dis_req = 0; wr_en = 0; wr_be = 4'h0;
  endtask

  task automatic tick(); @(negedge clk); clr_in(); endtask

  task automatic wr(input bit sel, input logic [3:0] be, input logic [31:0] d);
    wr_en = 1; wr_sel = sel; wr_be = be; wr_data = d; tick();
  endtask

  task automatic run_test();
    @(negedge clk);
    total++;
    if (status !== 32'h0 || hs_valid || hs_nak || irq) begin
      bad++;
      $display("FAIL R12 reset actual=%h expected=0", status);
    end
    rst_n = 1;
    @(negedge clk);
    // R6: five setups in a row on a control endpoint
    for (int i = 0; i < 5; i++) begin tok_setup = 1; tick(); end
    // R3: OUT after SETUP ends the setup stage; R4 overrun with low space
    fifo_free = 8'd3; tok_out = 1; tick();
    pkt_done = 1; tick(); tick();                    // R5 NAK
    fifo_free = 8'd16; tok_out = 1; tick();
    pkt_done = 1; tick(); tick();                    // R5 ACK at boundary
    tok_setup = 1; tick(); pkt_done = 1; tick(); tick(); // R5 setup ACK
    pkt_done = 1; tick();                            // R5 no pending token
    // R11 mask then R8 partial writes ignored
    wr(1'b1, 4'hF, 32'hFFFF_FFFF);
    wr(1'b0, 4'h7, 32'hFFFF_FFFF);
    wr(1'b1, 4'h1, 32'h0);
    // R9: set and clear same bit in same cycle
    xfer_done = 1; wr(1'b0, 4'hF, 32'h1);
    // R7: clear all, write zero does nothing
    wr(1'b0, 4'hF, 32'h0);
    wr(1'b0, 4'hF, 32'hFFFF_FFFF);
    // R2, R1
    dis_req = 1; tick(); xfer_done = 1; tick();
    // R3/R6 non-control endpoint
    is_ctrl = 0;
    for (int i = 0; i < 5; i++) begin tok_setup = 1; tick(); end
    tok_in = 1; tick();
    is_ctrl = 1;
    for (int i = 0; i < 3; i++) begin tok_setup = 1; tick(); end
    tok_in = 1; tick();
    tok_setup = 1; tick();
    // random phase
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 30) tok_setup = 1;
      else if (r < 40) tok_out = 1;
      else if (r < 45) tok_in = 1;
      else if (r < 60) pkt_done = 1;
      fifo_free = FW'($urandom_range(8, 24));
      xfer_done = ($urandom_range(0, 19) == 0);
      dis_req = ($urandom_range(0, 19) == 0);
      if ($urandom_range(0, 49) == 0) is_ctrl = ~is_ctrl;
      if ($urandom_range(0, 5) == 0) begin
        wr_en = 1; wr_sel = $urandom_range(0, 1);
        wr_be = ($urandom_range(0, 2) != 0) ? 4'hF : 4'($urandom_range(0, 14));
        wr_data = $urandom;
      end
      tick();
    end
    tick(); tick();
  endtask

  initial begin
    fork
      run_test();
      begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule